// File: doc/BRIEF.md
# IDE channel interrupt router

This block takes the raw interrupt requests of the two channels of a disk controller, primary and secondary, and presents them to the system. Each channel has a pending flag. The flag sets on a rising edge of the channel's raw request and stays set until software clears it through a small register bus. The flags then drive one of two output styles. In legacy mode, each channel drives its own active-high line. In native mode, both channels share one active-low line that behaves like a PCI interrupt.

Software picks the style through a mode register. A write that moves the block from legacy into native mode starts a mask window. The length of the window is set by the `mask_cycles` input. While the window is open the shared line is held inactive. When the window closes, the block looks at the pending flags again. If a flag is still set, the shared line asserts at that point. This covers a request that was left pending across the mode change, or one that arrived during the window. All outputs, including the read data, are registered.

Top module: `ide_irq_router`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, both legacy lines are 0, `native_irq_n` is 1, both pending flags are clear and the mode is legacy.
- R2: A 0-to-1 transition of a channel's raw request, sampled on a clock edge, sets that channel's pending flag. A raw request that stays high does not set the flag again after it has been cleared. The flag reads back as bit 2 of the status byte: address 0x2 for the primary channel (raw bit 0) and address 0xA for the secondary channel (raw bit 1). All other bits of a status byte read 0.
- R3: A write of a byte with bit 2 set to a channel's status address clears that channel's flag. Writing 0 in bit 2 leaves the flag unchanged. Writing to one channel's address leaves the other channel's flag unchanged.
- R4: If a rising edge and a clearing write land on the same clock edge, the flag ends up set.
- R5: In legacy mode, each legacy line (primary, secondary) equals its channel's pending flag one clock later, and `native_irq_n` stays 1.
- R6: In native mode with no mask open, both legacy lines are 0 and `native_irq_n` is the inverse of the OR of the two pending flags, one clock later.
- R7: A write to address 0x4 with bit 0 set, made while the mode is legacy, selects native mode and opens a mask of M = `mask_cycles` clocks. Counting the write edge as edge k, `native_irq_n` stays 1 through edge k+M. It asserts after edge k+M+1 if a flag is pending.
- R8: A flag that sets while the mask is open does not reach `native_irq_n` until the mask ends. The line then asserts on the same edge as in R7.
- R9: Address 0x4 reads back the mode in bit 0 (1 = native). Writing 0 there returns the block to legacy mode. Read data is registered: it reflects the address presented one clock earlier.
- R10: A write that selects native mode while the block is already native does not reopen the mask, so an asserted `native_irq_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_irq_raw | input | 2 | Raw requests, active high; bit 0 primary, bit 1 secondary |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address for reads and writes |
| reg_wdata | input | DATA_W (8) | Write data |
| mask_cycles | input | CNT_W (8) | Length of the mask window opened by entering native mode |
| reg_rdata | output | DATA_W (8) | Registered read data |
| legacy_irq_pri | output | 1 | Primary legacy interrupt, active high |
| legacy_irq_sec | output | 1 | Secondary legacy interrupt, active high |
| native_irq_n | output | 1 | Shared native interrupt, active low |

## Verification
Two things can land on the same clock edge and must be checked together. The first is a raw request rising while software clears the same flag. The bench provokes this by raising the primary request on the very edge that carries a clearing write. It then judges the result by reading the status byte and watching the legacy line: the set must win. The second overlap is a pending request meeting the end of the mask window. The bench sweeps the mask length from 0 to 5 clocks and samples `native_irq_n` after every edge following the mode write. It expects the line to fall on exactly edge k+M+1, and it repeats this for a request that first arrives inside the window.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_CH      = 2;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 8;
  localparam int CNT_W       = 8;
  localparam int PEND_BIT    = 2;
  localparam int MODE_BIT    = 0;
  localparam int MODE_OFF    = 4;
  localparam int STAT_BASE   = 2;
  localparam int STAT_STRIDE = 8;

  // byte address of a channel's status register
  function automatic int stat_off(input int ch);
    return STAT_BASE + ch * STAT_STRIDE;
  endfunction
endpackage

// File: rtl/ide_irq_chan_status.sv
module ide_irq_chan_status (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic clr,
  output logic pend
);
  logic raw_q;
  logic rise;

  assign rise = raw & ~raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      raw_q <= raw;
      if (rise)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst) rise |=> pend);

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst) (clr && !rise) |=> !pend);

  // R2
  level_no_reset_chk: assert property (@(posedge clk) disable iff (rst) (raw_q && !pend) |=> !pend);
endmodule

// File: rtl/ide_irq_mask_timer.sv
module ide_irq_mask_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] len,
  output logic             masking
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || stop)      cnt <= '0;
    else if (start)       cnt <= len;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign masking = (cnt != '0);

  // R7
  start_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !stop && len != '0) |=> masking);
endmodule

// File: rtl/ide_irq_router.sv
module ide_irq_router #(
  parameter int ADDR_W = ide_irq_pkg::ADDR_W,
  parameter int DATA_W = ide_irq_pkg::DATA_W,
  parameter int CNT_W  = ide_irq_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        chan_irq_raw,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  mask_cycles,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              legacy_irq_pri,
  output logic              legacy_irq_sec,
  output logic              native_irq_n
);
  import ide_irq_pkg::*;

  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFF);

  logic              mode_q;
  logic              mode_wr;
  logic              go_native;
  logic              go_legacy;
  logic              masking;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] clr;
  logic [DATA_W-1:0] rd_next;

  assign mode_wr   = reg_wr && (reg_addr == MODE_A);
  assign go_native = mode_wr && reg_wdata[MODE_BIT] && !mode_q;
  assign go_legacy = mode_wr && !reg_wdata[MODE_BIT];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign clr[c] = reg_wr && (reg_addr == ADDR_W'(stat_off(c))) && reg_wdata[PEND_BIT];
      ide_irq_chan_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .raw  (chan_irq_raw[c]),
        .clr  (clr[c]),
        .pend (pend[c])
      );
    end
  endgenerate

  ide_irq_mask_timer #(.CNT_W(CNT_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .start   (go_native),
    .stop    (go_legacy),
    .len     (mask_cycles),
    .masking (masking)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr == MODE_A) rd_next[MODE_BIT] = mode_q;
    for (int c = 0; c < NUM_CH; c++)
      if (reg_addr == ADDR_W'(stat_off(c))) rd_next[PEND_BIT] = pend[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q         <= 1'b0;
      reg_rdata      <= '0;
      legacy_irq_pri <= 1'b0;
      legacy_irq_sec <= 1'b0;
      native_irq_n   <= 1'b1;
    end else begin
      if (mode_wr) mode_q <= reg_wdata[MODE_BIT];
      reg_rdata      <= rd_next;
      legacy_irq_pri <= !mode_q && pend[0];
      legacy_irq_sec <= !mode_q && pend[1];
      native_irq_n   <= !(mode_q && !masking && (|pend));
    end
  end

  // R5
  legacy_quiet_chk: assert property (@(posedge clk) disable iff (rst) !mode_q |=> native_irq_n);

  // R6
  native_lines_off_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> (!legacy_irq_pri && !legacy_irq_sec));

  // R6
  native_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !masking && (|pend)) |=> !native_irq_n);

  // R8
  mask_holds_chk: assert property (@(posedge clk) disable iff (rst) masking |=> native_irq_n);
endmodule

// File: tb/ide_irq_router_test.sv
`timescale 1ns/1ps
module ide_irq_router_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] chan_irq_raw = 2'b00;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] mask_cycles = 8'd0;
  logic [7:0] reg_rdata;
  logic       legacy_irq_pri, legacy_irq_sec, native_irq_n;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ide_irq_router uut (
    .clk(clk), .rst(rst), .chan_irq_raw(chan_irq_raw), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mask_cycles(mask_cycles),
    .reg_rdata(reg_rdata), .legacy_irq_pri(legacy_irq_pri),
    .legacy_irq_sec(legacy_irq_sec), .native_irq_n(native_irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clear_all();
    wr(4'h2, 8'h04);
    wr(4'hA, 8'h04);
  endtask

  // raise a raw pattern, drop it, and let the outputs settle
  task automatic pulse(input logic [1:0] p);
    @(negedge clk); chan_irq_raw = p;
    @(negedge clk); chan_irq_raw = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 legacy_pri", legacy_irq_pri, 0);
    check("R1 legacy_sec", legacy_irq_sec, 0);
    check("R1 native_n", native_irq_n, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 native_n after release", native_irq_n, 1);
    rd(4'h2, r); check("R1 primary flag", r, 0);
    rd(4'hA, r); check("R1 secondary flag", r, 0);
    rd(4'h4, r); check("R1 mode", r, 0);

    // R2 R5: legacy sweep over all request patterns
    for (int p = 0; p < 4; p++) begin
      clear_all();
      pulse(2'(p));
      check("R5 legacy_pri", legacy_irq_pri, p & 1);
      check("R5 legacy_sec", legacy_irq_sec, (p >> 1) & 1);
      check("R5 native_n idle", native_irq_n, 1);
      rd(4'h2, r); check("R2 primary status", r, (p & 1) * 4);
      rd(4'hA, r); check("R2 secondary status", r, ((p >> 1) & 1) * 4);
    end

    // R3: write-0 and other-channel writes leave a flag
    clear_all();
    pulse(2'b01);
    wr(4'h2, 8'hFB);
    rd(4'h2, r); check("R3 write zero keeps flag", r, 4);
    wr(4'hA, 8'h04);
    rd(4'h2, r); check("R3 other channel keeps flag", r, 4);
    wr(4'h2, 8'h04);
    rd(4'h2, r); check("R3 clear", r, 0);
    @(negedge clk);
    check("R3 legacy line drops", legacy_irq_pri, 0);

    // R2: held high level does not re-set after clear
    @(negedge clk); chan_irq_raw = 2'b01;
    @(negedge clk);
    wr(4'h2, 8'h04);
    rd(4'h2, r); check("R2 held level no reset", r, 0);
    chan_irq_raw = 2'b00;

    // R4: rise and clear on the same edge
    @(negedge clk);
    chan_irq_raw = 2'b01; reg_wr = 1'b1; reg_addr = 4'h2; reg_wdata = 8'h04;
    @(negedge clk);
    reg_wr = 1'b0; chan_irq_raw = 2'b00;
    @(negedge clk);
    check("R4 legacy line after collision", legacy_irq_pri, 1);
    rd(4'h2, r); check("R4 set wins", r, 4);

    // R9 and R6: native sweep with no mask
    mask_cycles = 8'd0;
    wr(4'h4, 8'h01);
    rd(4'h4, r); check("R9 mode readback native", r, 1);
    for (int p = 0; p < 4; p++) begin
      clear_all();
      pulse(2'(p));
      check("R6 legacy_pri off", legacy_irq_pri, 0);
      check("R6 legacy_sec off", legacy_irq_sec, 0);
      check("R6 native_n", native_irq_n, (p != 0) ? 0 : 1);
    end

    // R10: re-selecting native keeps an asserted line low
    clear_all();
    pulse(2'b10);
    mask_cycles = 8'd5;
    wr(4'h4, 8'h01);
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      check("R10 no remask", native_irq_n, 0);
    end

    // R7: sweep mask length with a request pending across the switch
    for (int m = 0; m < 6; m++) begin
      wr(4'h4, 8'h00);
      clear_all();
      pulse(2'b01);
      mask_cycles = 8'(m);
      wr(4'h4, 8'h01);
      check("R7 write edge", native_irq_n, 1);
      for (int j = 1; j <= m + 2; j++) begin
        @(negedge clk);
        check("R7 mask window", native_irq_n, (j >= m + 1) ? 0 : 1);
      end
    end

    // R8: request arriving inside the mask
    wr(4'h4, 8'h00);
    clear_all();
    mask_cycles = 8'd4;
    wr(4'h4, 8'h01);
    chan_irq_raw = 2'b10;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      chan_irq_raw = 2'b00;
      check("R8 late request", native_irq_n, (j >= 5) ? 0 : 1);
    end

    // R9: back to legacy
    wr(4'h4, 8'h00);
    rd(4'h4, r); check("R9 mode readback legacy", r, 0);
    check("R9 native_n released", native_irq_n, 1);
    check("R9 legacy_sec resumes", legacy_irq_sec, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule